// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex clocked serial shifter of the kind found in the byte-wide shift mode of a small controller's serial port. One data pin carries bits in both directions. It is split into an input, an output and an output-enable. A second pin drives the shift clock. The block moves one byte per request, least significant bit first. Each bit lasts twelve core-clock enables. The shift clock is low for the first half of each bit and high for the second half.

A transmit starts when a byte is accepted on the transmit stream port. That port uses a valid/ready handshake, and `tx_ready_o` is high only while the block is idle and the mode select reads zero. A byte accepted while idle is sent. A valid presented while ready is low is dropped, not queued, and it leaves the frame in flight unchanged.

The receive side presents its byte through `rx_valid_o`, which is the receive flag, together with `rx_data_o`. The consumer takes the byte with `rx_ready_i`. While the flag is up, the receiver is stalled and no shift clocks are produced. This is the receive back-pressure. As soon as the byte is taken with reception still enabled, the next reception starts. The transmit-done flag stays set until it is cleared through `ti_clr_i`.

Top module: `sync_shift_port`

## Requirements
- R1: Transfers happen only while `mode_i` equals 2'b00. With any other value, `tx_ready_o` stays low, no reception starts and `sclk_o` stays high.
- R2: In mode 2'b00 with the block idle, `tx_ready_o` is high. A cycle with `tx_valid_i` and `tx_ready_o` both high starts a transmit of `tx_data_i`.
- R3: A transmit puts exactly eight bits on `sdata_o`, least significant bit first. `sdata_o` changes only while `sclk_o` is low, so every bit is stable across its rising clock edge.
- R4: Each bit spans twelve cycles in which `tick_i` is high. `sclk_o` is low for the first six of those cycles and high for the last six, and the phase does not advance in cycles where `tick_i` is low.
- R5: `ti_o` goes high once the eighth transmitted bit period ends. It stays high until `ti_clr_i` is asserted.
- R6: A reception starts when mode is 2'b00, the block is idle, `rx_en_i` is 1 and `rx_valid_o` is 0. During reception `sdata_oe_o` is 0, and `sdata_i` is sampled at each rising edge of `sclk_o`. The first sample becomes bit 0.
- R7: After eight samples, the byte appears on `rx_data_o` and `rx_valid_o` goes high. It holds until `rx_ready_i` is asserted. While it holds, no shift clocks are produced.
- R8: A `tx_valid_i` presented during a transfer has no effect. `tx_ready_o` is low, the frame in flight completes unchanged, and no extra bits follow it.
- R9: When idle and after reset, `sclk_o` is 1, `sdata_o` is 1 and `sdata_oe_o` is 1. Also after reset, `ti_o` is 0 and `rx_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Core clock enable; one shift phase step per high cycle |
| mode_i | input | 2 | Port mode select; 2'b00 enables this shift mode |
| rx_en_i | input | 1 | Receive enable |
| tx_valid_i | input | 1 | Transmit byte valid |
| tx_data_i | input | 8 | Transmit byte |
| tx_ready_o | output | 1 | Transmit byte can be accepted |
| ti_o | output | 1 | Transmit done flag |
| ti_clr_i | input | 1 | Clears the transmit done flag |
| rx_valid_o | output | 1 | Receive flag; received byte available |
| rx_ready_i | input | 1 | Consumer takes the received byte and clears the flag |
| rx_data_o | output | 8 | Received byte |
| sclk_o | output | 1 | Shift clock, high when idle |
| sdata_o | output | 1 | Data pin output value |
| sdata_oe_o | output | 1 | Data pin output enable, low during reception |
| sdata_i | input | 1 | Data pin input value |

## Verification
The hardest conditions to reach from the ports are a write that lands in the middle of a frame and a reception that restarts on the very cycle the flag is taken. The stimulus injects a second write about thirty cycles into a transmit. It then checks that the captured bits still match the first byte and that no ninth clock appears. For receive, the bench keeps enable high and acknowledges the flag with a fresh pattern already loaded in the slave model, so the next byte is clocked back to back. Random bytes run at tick rates of one in one, two and three cycles. This shows that the bit period tracks the enable rather than the clock.

// File: rtl/sync_shift_pkg.sv
package sync_shift_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_RX   = 2'd2
  } xfer_state_e;

  localparam logic [1:0] MODE_SHIFT = 2'b00;

endpackage

// File: rtl/sync_shift_timer.sv
module sync_shift_timer #(
  parameter int DIV   = 12,
  parameter int NBITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic run_i,
  input  logic start_i,
  output logic sclk_o,
  output logic rise_o,
  output logic bit_end_o,
  output logic last_o
);

  localparam int PH_W = $clog2(DIV);
  localparam int BC_W = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam int HALF = DIV / 2;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(HALF - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(NBITS - 1);

  logic [PH_W-1:0] ph_q;
  logic [BC_W-1:0] bc_q;
  logic            step;

  assign step = run_i && tick_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= '0;
      bc_q <= '0;
    end else if (start_i) begin
      ph_q <= '0;
      bc_q <= '0;
    end else if (step) begin
      if (ph_q == PH_LAST) begin
        ph_q <= '0;
        bc_q <= (bc_q == BC_LAST) ? '0 : bc_q + 1'b1;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  // low half first, high half second; high while not running
  assign sclk_o    = !(run_i && (ph_q < PH_HALF));
  assign rise_o    = step && (ph_q == PH_RISE);
  assign bit_end_o = step && (ph_q == PH_LAST);
  assign last_o    = bit_end_o && (bc_q == BC_LAST);

  // R4
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(ph_q));

  // R4
  sclk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> $rose(sclk_o));

endmodule

// File: rtl/sync_shift_datapath.sv
module sync_shift_datapath #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_out_i,
  input  logic         sample_i,
  input  logic         sdata_i,
  input  logic         commit_i,
  output logic         tx_bit_o,
  output logic [W-1:0] rx_data_o
);

  logic [W-1:0] shreg_q;
  logic [W-1:0] rx_buf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q <= '1;
    end else if (load_i) begin
      shreg_q <= data_i;
    end else if (sample_i) begin
      shreg_q <= {sdata_i, shreg_q[W-1:1]};
    end else if (shift_out_i) begin
      shreg_q <= {1'b1, shreg_q[W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_buf_q <= '0;
    end else if (commit_i) begin
      rx_buf_q <= shreg_q;
    end
  end

  assign tx_bit_o  = shreg_q[0];
  assign rx_data_o = rx_buf_q;

endmodule

// File: rtl/sync_shift_ctrl.sv
module sync_shift_ctrl
  import sync_shift_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       rx_en_i,
  input  logic       tx_valid_i,
  input  logic       ti_clr_i,
  input  logic       rx_ready_i,
  input  logic       last_i,
  output logic       tx_ready_o,
  output logic       load_o,
  output logic       start_o,
  output logic       run_o,
  output logic       tx_busy_o,
  output logic       rx_busy_o,
  output logic       ti_o,
  output logic       ri_o
);

  xfer_state_e state_q;
  logic        ti_q;
  logic        ri_q;
  logic        idle_ok;
  logic        accept;
  logic        rx_go;

  assign idle_ok    = (state_q == ST_IDLE) && (mode_i == MODE_SHIFT);
  assign tx_ready_o = idle_ok;
  assign accept     = tx_valid_i && idle_ok;
  assign rx_go      = idle_ok && rx_en_i && !ri_q && !accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept)      state_q <= ST_TX;
          else if (rx_go)  state_q <= ST_RX;
        end
        ST_TX:   if (last_i) state_q <= ST_IDLE;
        ST_RX:   if (last_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ti_q <= 1'b0;
      ri_q <= 1'b0;
    end else begin
      if (state_q == ST_TX && last_i) ti_q <= 1'b1;
      else if (ti_clr_i)              ti_q <= 1'b0;
      if (state_q == ST_RX && last_i) ri_q <= 1'b1;
      else if (rx_ready_i)            ri_q <= 1'b0;
    end
  end

  assign load_o    = accept;
  assign start_o   = accept || rx_go;
  assign tx_busy_o = (state_q == ST_TX);
  assign rx_busy_o = (state_q == ST_RX);
  assign run_o     = tx_busy_o || rx_busy_o;
  assign ti_o      = ti_q;
  assign ri_o      = ri_q;

  // R5
  ti_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ti_q) |-> $past(state_q == ST_TX));

  // R7
  ri_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ri_q && !rx_ready_i) |=> ri_q);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TX && !last_i) |=> (state_q == ST_TX));

  // R6
  rx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && mode_i == MODE_SHIFT && rx_en_i && !ri_q && !tx_valid_i)
      |=> (state_q == ST_RX));

endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
  parameter int DIV = 12,
  parameter int W   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic [1:0]   mode_i,
  input  logic         rx_en_i,
  input  logic         tx_valid_i,
  input  logic [W-1:0] tx_data_i,
  output logic         tx_ready_o,
  output logic         ti_o,
  input  logic         ti_clr_i,
  output logic         rx_valid_o,
  input  logic         rx_ready_i,
  output logic [W-1:0] rx_data_o,
  output logic         sclk_o,
  output logic         sdata_o,
  output logic         sdata_oe_o,
  input  logic         sdata_i
);

  logic load, start, run, tx_busy, rx_busy;
  logic rise, bit_end, last, tx_bit;

  sync_shift_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .rx_en_i    (rx_en_i),
    .tx_valid_i (tx_valid_i),
    .ti_clr_i   (ti_clr_i),
    .rx_ready_i (rx_ready_i),
    .last_i     (last),
    .tx_ready_o (tx_ready_o),
    .load_o     (load),
    .start_o    (start),
    .run_o      (run),
    .tx_busy_o  (tx_busy),
    .rx_busy_o  (rx_busy),
    .ti_o       (ti_o),
    .ri_o       (rx_valid_o)
  );

  sync_shift_timer #(.DIV(DIV), .NBITS(W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .run_i     (run),
    .start_i   (start),
    .sclk_o    (sclk_o),
    .rise_o    (rise),
    .bit_end_o (bit_end),
    .last_o    (last)
  );

  sync_shift_datapath #(.W(W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .data_i      (tx_data_i),
    .shift_out_i (bit_end && tx_busy),
    .sample_i    (rise && rx_busy),
    .sdata_i     (sdata_i),
    .commit_i    (last && rx_busy),
    .tx_bit_o    (tx_bit),
    .rx_data_o   (rx_data_o)
  );

  assign sdata_o    = tx_busy ? tx_bit : 1'b1;
  assign sdata_oe_o = !rx_busy;

  // R3
  tx_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && (sdata_o != $past(sdata_o))) |-> !sclk_o);

endmodule

// File: tb/sync_shift_port_bench.sv
module sync_shift_port_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       rx_en_i = 1'b0;
  logic       tx_valid_i = 1'b0;
  logic [7:0] tx_data_i = 8'h00;
  logic       ti_clr_i = 1'b0;
  logic       rx_ready_i = 1'b0;
  logic       sdata_i = 1'b1;
  logic       tx_ready_o, ti_o, rx_valid_o, sclk_o, sdata_o, sdata_oe_o;
  logic [7:0] rx_data_o;

  int checks = 0, fails = 0, cyc = 0, tick_div = 1;
  int rises = 0, last_rise = 0, fall_cyc = 0;
  int per_bad = 0, low_bad = 0, oe_bad = 0;
  logic oe_exp = 1'b1;
  logic [7:0] pat = 8'h00;
  logic [7:0] cap = 8'h00;
  logic sclk_q = 1'b1;
  bit done = 0;

  always #4 clk = ~clk;

  sync_shift_port u_sync_shift_port (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .mode_i(mode_i),
    .rx_en_i(rx_en_i), .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i),
    .tx_ready_o(tx_ready_o), .ti_o(ti_o), .ti_clr_i(ti_clr_i),
    .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i), .rx_data_o(rx_data_o),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o), .sdata_i(sdata_i)
  );

  function automatic int exp_period(input int d);
    return 12 * d;
  endfunction

  function automatic int exp_low(input int d);
    return 6 * d;
  endfunction

  // slave device model and clock-shape monitor, away from the active edge
  always @(negedge clk) begin
    cyc++;
    tick_i = (tick_div <= 1) ? 1'b1 : ((cyc % tick_div) == 0);
    if (!sclk_o && sclk_q) fall_cyc = cyc;
    if (sclk_o && !sclk_q) begin
      if (rises < 8) cap[rises] = sdata_o;
      if (sdata_oe_o != oe_exp) oe_bad++;
      if (rises > 0) begin
        if (cyc - last_rise != exp_period(tick_div)) per_bad++;
        if (cyc - fall_cyc != exp_low(tick_div)) low_bad++;
      end
      last_rise = cyc;
      rises++;
      if (rises < 8) sdata_i = pat[rises];
    end
    sclk_q = sclk_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic clear_meas();
    rises = 0; per_bad = 0; low_bad = 0; oe_bad = 0; cap = 8'h00;
  endtask

  task automatic do_tx(input logic [7:0] d, input int div, input bit inject);
    tick_div = div;
    oe_exp = 1'b1;
    clear_meas();
    @(negedge clk);
    check(tx_ready_o == 1'b1, "R2 ready when idle", int'(tx_ready_o), 1);
    tx_data_i = d; tx_valid_i = 1'b1;
    @(negedge clk);
    tx_valid_i = 1'b0;
    if (inject) begin
      repeat (30) @(negedge clk);
      check(tx_ready_o == 1'b0, "R8 ready low while busy", int'(tx_ready_o), 0);
      tx_data_i = ~d; tx_valid_i = 1'b1;
      @(negedge clk);
      tx_valid_i = 1'b0;
    end
    for (int i = 0; i < 4000 && !ti_o; i++) @(negedge clk);
    check(ti_o == 1'b1, "R5 ti after frame", int'(ti_o), 1);
    check(cap == d, "R3 bits lsb first", int'(cap), int'(d));
    check(rises == 8, "R3 eight clocks", rises, 8);
    check(per_bad == 0, "R4 bit period", per_bad, 0);
    check(low_bad == 0, "R4 low half", low_bad, 0);
    check(oe_bad == 0, "R3 driving during tx", oe_bad, 0);
    check(sdata_o == 1'b1 && sdata_oe_o == 1'b1 && sclk_o == 1'b1, "R9 idle pins",
          int'({sclk_o, sdata_oe_o, sdata_o}), 7);
    if (inject) begin
      repeat (50) @(negedge clk);
      check(rises == 8, "R8 no extra frame", rises, 8);
      check(cap == d, "R8 frame intact", int'(cap), int'(d));
    end
    ti_clr_i = 1'b1;
    @(negedge clk);
    ti_clr_i = 1'b0;
    check(ti_o == 1'b0, "R5 ti cleared", int'(ti_o), 0);
  endtask

  task automatic do_rx(input logic [7:0] p, input int div, input bit first);
    tick_div = div;
    oe_exp = 1'b0;
    clear_meas();
    pat = p;
    sdata_i = p[0];
    if (first) begin
      rx_en_i = 1'b1;
    end else begin
      rx_ready_i = 1'b1;
      @(negedge clk);
      rx_ready_i = 1'b0;
      check(rx_valid_o == 1'b0, "R7 flag taken", int'(rx_valid_o), 0);
    end
    for (int i = 0; i < 4000 && !rx_valid_o; i++) @(negedge clk);
    check(rx_valid_o == 1'b1, "R7 flag set", int'(rx_valid_o), 1);
    check(rx_data_o == p, "R6 received byte", int'(rx_data_o), int'(p));
    check(rises == 8, "R6 eight clocks", rises, 8);
    check(oe_bad == 0, "R6 pin released", oe_bad, 0);
    check(per_bad == 0, "R4 rx bit period", per_bad, 0);
    repeat (40) @(negedge clk);
    check(rises == 8 && rx_valid_o == 1'b1, "R7 stall while flag held", rises, 8);
    check(sclk_o == 1'b1, "R7 clock idle", int'(sclk_o), 1);
  endtask

  initial begin
    void'($urandom(32'd77));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sclk_o == 1'b1 && sdata_o == 1'b1 && sdata_oe_o == 1'b1, "R9 reset pins",
          int'({sclk_o, sdata_oe_o, sdata_o}), 7);
    check(ti_o == 1'b0 && rx_valid_o == 1'b0, "R9 reset flags", int'({ti_o, rx_valid_o}), 0);

    do_tx(8'hA5, 1, 1'b0);
    do_tx(8'h01, 1, 1'b0);
    do_tx(8'h80, 2, 1'b1);
    for (int k = 0; k < 6; k++)
      do_tx(8'($urandom % 256), 1 + int'($urandom % 3), bit'($urandom % 2));

    // R1: other modes leave the port inert
    for (int k = 0; k < 3; k++) begin
      clear_meas();
      mode_i = 2'(k + 1);
      rx_en_i = 1'b1; tx_valid_i = 1'b1; tx_data_i = 8'h5A;
      @(negedge clk);
      check(tx_ready_o == 1'b0, "R1 no ready in other mode", int'(tx_ready_o), 0);
      repeat (100) @(negedge clk);
      check(rises == 0 && sclk_o == 1'b1, "R1 no clocks in other mode", rises, 0);
      check(ti_o == 1'b0 && rx_valid_o == 1'b0, "R1 no flags in other mode",
            int'({ti_o, rx_valid_o}), 0);
      tx_valid_i = 1'b0; rx_en_i = 1'b0;
      @(negedge clk);
      mode_i = 2'b00;
    end

    do_rx(8'h3C, 1, 1'b1);
    for (int k = 0; k < 4; k++)
      do_rx(8'($urandom % 256), 1 + int'($urandom % 3), 1'b0);

    // R6: enable low, flag taken, no new reception
    rx_en_i = 1'b0;
    rx_ready_i = 1'b1;
    @(negedge clk);
    rx_ready_i = 1'b0;
    clear_meas();
    repeat (60) @(negedge clk);
    check(rises == 0 && rx_valid_o == 1'b0, "R6 disabled receiver idle", rises, 0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule